// File: doc/BRIEF.md
# Serial Transfer Cycle Timing Monitor

This block watches the strobe and serial clock inputs that drive a dual-port memory's transfer engine, and reports any transfer cycle that breaks the protocol. All inputs are sampled on the system clock. A two-bit cycle kind is decoded outside the block and is read in the cycle where the active-low row strobe falls. Every spacing limit is a parameter counted in system-clock cycles. For example, a 30 ns minimum at 100 MHz is 3 cycles.

Four rules are checked. The serial clock must be frozen while the row strobe of a write or pseudo-write transfer is low. The serial clock may not rise too soon after such a transfer ends. The column strobe must fall during every transfer. A read transfer must not start too soon after the first serial clock rise that follows an earlier read transfer. Each rule has its own sticky flag. The code of the first violation is kept until software pulses the clear input. A one-cycle pulse marks every cycle that contains a violation.

Top module: `xfer_timing_mon`

## Requirements
- R1: Cycle kinds are 0 = none, 1 = read transfer, 2 = write transfer, 3 = pseudo-write transfer. The kind is captured in the cycle where row_stb_n falls. For kinds 2 and 3, a ser_clk change (either direction) in any later cycle while row_stb_n is still low sets flag bit 0. The violation code for this rule is 1.
- R2: After a kind 2 or 3 transfer ends, count the cycles from the cycle where row_stb_n rises (k = 0). A ser_clk rise at k < SRD_CYC sets flag bit 1 with code 2. A rise at k = SRD_CYC is legal.
- R3: A transfer of kind 1, 2 or 3 in which col_stb_n does not fall sets flag bit 2 with code 3. The window runs from the cycle after the row fall up to and including the row rise cycle. The flag is set in the row rise cycle.
- R4: After a read transfer ends, count the cycles from the first ser_clk rise that follows (k = 0). A read transfer that starts at k < RR_CYC, or before any such rise, sets flag bit 3 with code 4. A start at k = RR_CYC is legal. The start of any transfer of kind 2 or 3 in between cancels the spacing check.
- R5: Row strobe cycles of kind 0 raise no violation and do not cancel the R4 check.
- R6: Flags are sticky until clear. viol_pulse is high in the cycle after each cycle that contains at least one violation.
- R7: viol_code holds the code of the first violation since reset or clear. When several rules fire in the same cycle, the lowest code wins.
- R8: A clear pulse zeroes flags and code from the next cycle on. A violation in the clear cycle itself is still recorded.
- R9: After reset, viol_pulse, viol_flags and viol_code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 1 | Sampled row strobe, active low |
| col_stb_n | input | 1 | Sampled column strobe, active low |
| ser_clk | input | 1 | Sampled serial clock |
| cyc_kind | input | 2 | Decoded cycle kind, valid in the row-fall cycle |
| clear | input | 1 | Clears flags and code |
| viol_pulse | output | 1 | One-cycle mark of a violating cycle |
| viol_flags | output | 4 | Sticky per-rule flags |
| viol_code | output | 3 | Code of the first violation, 0 when none |

## Verification
The assertions assume that every input is already synchronous to clk and changes at most once per cycle. They also assume that cyc_kind is meaningful only in the cycle where the row strobe falls, and that the spacing parameters are at least one. The stimulus changes inputs only on the falling clock edge. It pairs random toggling of the strobes, the serial clock, the kind and the clear input with directed sequences that place serial clock and read-start events exactly one cycle before, and exactly on, each spacing limit. These sequences also cover simultaneous violations and a violation in the clear cycle.

// File: rtl/xfer_mon_pkg.sv
package xfer_mon_pkg;
   localparam int NUM_RULES = 4;
   localparam int CODE_W    = 3;
   localparam int KIND_W    = 2;

   typedef enum logic [KIND_W-1:0] {
      KIND_IDLE = 2'd0,
      KIND_RD   = 2'd1,
      KIND_WR   = 2'd2,
      KIND_PWR  = 2'd3
   } xfer_kind_e;

   localparam int RULE_MOVE  = 0;
   localparam int RULE_EARLY = 1;
   localparam int RULE_NOCOL = 2;
   localparam int RULE_RDGAP = 3;

   // lowest set rule wins; code is rule index plus one
   function automatic logic [CODE_W-1:0] first_code(input logic [NUM_RULES-1:0] h);
      logic [CODE_W-1:0] c;
      c = '0;
      for (int i = NUM_RULES - 1; i >= 0; i--) begin
         if (h[i]) c = CODE_W'(i + 1);
      end
      return c;
   endfunction
endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler #(
   parameter int          W       = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("strobe_sampler: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
   end
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic clr,
   output logic busy
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("gap_timer: LIMIT must be at least 1");
   end

   if (LIMIT > 1) begin : g_cnt
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt <= '0;
         else if (clr)            cnt <= '0;
         else if (start)          cnt <= CW'(LIMIT - 1);
         else if (cnt != '0)      cnt <= cnt - 1'b1;
      end
      assign busy = (cnt != '0);

      assert_timer_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (start && !clr) |=> busy)
         else $error("timer not busy after start");
   end else begin : g_none
      assign busy = 1'b0;
   end
endmodule

// File: rtl/viol_log.sv
module viol_log
   import xfer_mon_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RULES-1:0] hits,
   input  logic                 clear,
   output logic                 pulse,
   output logic [NUM_RULES-1:0] flags,
   output logic [CODE_W-1:0]    code
);
   logic fresh;
   assign fresh = clear || (flags == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse <= 1'b0;
         flags <= '0;
         code  <= '0;
      end else begin
         pulse <= |hits;
         flags <= (clear ? '0 : flags) | hits;
         if (fresh && (hits != '0)) code <= first_code(hits);
         else if (clear)            code <= '0;
      end
   end

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((flags & $past(flags)) == $past(flags)))
      else $error("flag dropped without clear");

   assert_pulse_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> (flags != '0))
      else $error("pulse without flag");

   assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((code != '0) && !clear) |=> (code == $past(code)))
      else $error("code changed without clear");

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && (hits == '0)) |=> ((flags == '0) && (code == '0)))
      else $error("clear did not empty the log");
endmodule

// File: rtl/xfer_timing_mon.sv
module xfer_timing_mon
   import xfer_mon_pkg::*;
#(
   parameter int SRD_CYC = 4,
   parameter int RR_CYC  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 row_stb_n,
   input  logic                 col_stb_n,
   input  logic                 ser_clk,
   input  logic [KIND_W-1:0]    cyc_kind,
   input  logic                 clear,
   output logic                 viol_pulse,
   output logic [NUM_RULES-1:0] viol_flags,
   output logic [CODE_W-1:0]    viol_code
);
   localparam int NSIG = 3;
   localparam logic [NSIG-1:0] IDLE_LVL = 3'b110;

   if (SRD_CYC < 1 || RR_CYC < 1) begin : g_bad_par
      $error("xfer_timing_mon: spacing limits must be at least 1");
   end

   logic [NSIG-1:0] now_s, prev_s;
   assign now_s = {row_stb_n, col_stb_n, ser_clk};

   strobe_sampler #(.W(NSIG), .RST_VAL(IDLE_LVL)) u_samp (
      .clk(clk), .rst_n(rst_n), .d(now_s), .q(prev_s));

   logic row_fall, row_rise, col_fall, sc_rise, sc_edge;
   assign row_fall = prev_s[2] && !row_stb_n;
   assign row_rise = !prev_s[2] && row_stb_n;
   assign col_fall = prev_s[1] && !col_stb_n;
   assign sc_rise  = !prev_s[0] && ser_clk;
   assign sc_edge  = prev_s[0] ^ ser_clk;

   logic       in_xfer, col_seen, rr_wait;
   xfer_kind_e kind_q;
   xfer_kind_e kind_in;
   assign kind_in = xfer_kind_e'(cyc_kind);

   logic wr_q, rd_q, start_any, start_rd, wr_end, rd_end;
   assign wr_q      = in_xfer && (kind_q == KIND_WR || kind_q == KIND_PWR);
   assign rd_q      = in_xfer && (kind_q == KIND_RD);
   assign start_any = row_fall && (kind_in == KIND_WR || kind_in == KIND_PWR);
   assign start_rd  = row_fall && (kind_in == KIND_RD);
   assign wr_end    = wr_q && row_rise;
   assign rd_end    = rd_q && row_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_xfer  <= 1'b0;
         kind_q   <= KIND_IDLE;
         col_seen <= 1'b0;
      end else if (row_fall) begin
         in_xfer  <= (kind_in != KIND_IDLE);
         kind_q   <= kind_in;
         col_seen <= 1'b0;
      end else if (row_rise) begin
         in_xfer  <= 1'b0;
      end else if (in_xfer && col_fall) begin
         col_seen <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rr_wait <= 1'b0;
      else if (start_any || start_rd) rr_wait <= 1'b0;
      else if (rd_end)                rr_wait <= 1'b1;
      else if (sc_rise)               rr_wait <= 1'b0;
   end

   logic srd_busy, rr_busy;

   gap_timer #(.LIMIT(SRD_CYC)) u_srd (
      .clk(clk), .rst_n(rst_n), .start(wr_end), .clr(1'b0), .busy(srd_busy));

   gap_timer #(.LIMIT(RR_CYC)) u_rr (
      .clk(clk), .rst_n(rst_n), .start(sc_rise && rr_wait), .clr(start_any),
      .busy(rr_busy));

   logic [NUM_RULES-1:0] hits;
   assign hits[RULE_MOVE]  = wr_q && !row_stb_n && sc_edge;
   assign hits[RULE_EARLY] = sc_rise && (wr_end || srd_busy);
   assign hits[RULE_NOCOL] = in_xfer && row_rise && !col_seen && !col_fall;
   assign hits[RULE_RDGAP] = start_rd && (rr_wait || rr_busy);

   viol_log u_log (
      .clk(clk), .rst_n(rst_n), .hits(hits), .clear(clear),
      .pulse(viol_pulse), .flags(viol_flags), .code(viol_code));

   assert_code_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_flags != '0) |-> (viol_code != '0))
      else $error("flags set but no code");

   assert_read_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_end |=> rr_wait)
      else $error("read end did not arm spacing check");

   assert_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_q && !row_stb_n && sc_edge) |=> viol_flags[RULE_MOVE])
      else $error("serial clock move not flagged");
endmodule

// File: tb/xfer_timing_mon_bench.sv
`timescale 1ns/1ps
module xfer_timing_mon_bench;
   localparam int SRD = 4;
   localparam int RR  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic row = 1'b1, col = 1'b1, sc = 1'b0, clr = 1'b0;
   logic [1:0] kind = 2'd0;
   logic       viol_pulse;
   logic [3:0] viol_flags;
   logic [2:0] viol_code;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   xfer_timing_mon #(.SRD_CYC(SRD), .RR_CYC(RR)) u_xfer_timing_mon (
      .clk(clk), .rst_n(rst_n), .row_stb_n(row), .col_stb_n(col), .ser_clk(sc),
      .cyc_kind(kind), .clear(clr), .viol_pulse(viol_pulse),
      .viol_flags(viol_flags), .viol_code(viol_code));

   // timestamp reference model
   longint t = 0, last_wr = -1000, rr_t = -1000;
   bit m_in = 0, m_col = 0, m_rrw = 0;
   logic [1:0] m_kind = 2'd0;
   logic p_row = 1'b1, p_col = 1'b1, p_sc = 1'b0;
   bit e_pulse = 0;
   logic [3:0] e_flags = '0;
   logic [2:0] e_code = '0;

   function automatic logic [2:0] low_code(input logic [3:0] h);
      for (int i = 0; i < 4; i++) if (h[i]) return 3'(i + 1);
      return 3'd0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_step();
      bit rf, rr, cf, se, sr, wq, rq, st_any, st_rd;
      logic [3:0] h;
      rf = p_row && !row;  rr = !p_row && row;
      cf = p_col && !col;  se = sc != p_sc;  sr = !p_sc && sc;
      wq = m_in && (m_kind == 2'd2 || m_kind == 2'd3);
      rq = m_in && (m_kind == 2'd1);
      st_any = rf && (kind == 2'd2 || kind == 2'd3);
      st_rd  = rf && (kind == 2'd1);
      h[0] = wq && !row && se;
      if (wq && rr) last_wr = t;
      h[1] = sr && (t - last_wr < SRD);
      h[2] = m_in && rr && !m_col && !cf;
      h[3] = st_rd && (m_rrw || (t - rr_t < RR));
      if (sr && m_rrw) begin rr_t = t; m_rrw = 0; end
      if (rq && rr) m_rrw = 1;
      if (st_any || st_rd) m_rrw = 0;
      if (st_any) rr_t = -1000;
      if (rf) begin m_in = (kind != 2'd0); m_kind = kind; m_col = 0; end
      else if (rr) m_in = 0;
      else if (m_in && cf) m_col = 1;
      e_pulse = |h;
      if (clr) begin e_flags = '0; e_code = '0; end
      if (h != '0 && e_flags == '0) e_code = low_code(h);
      e_flags |= h;
      p_row = row; p_col = col; p_sc = sc;
      t++;
   endtask

   task automatic drive(input logic r, input logic c, input logic s,
                        input logic [1:0] k, input logic cl);
      @(negedge clk);
      row = r; col = c; sc = s; kind = k; clr = cl;
      @(posedge clk);
      model_step();
      #1;
      check(viol_pulse == e_pulse, "R6 pulse", viol_pulse, e_pulse);
      check(viol_flags == e_flags, "R6 flags", viol_flags, e_flags);
      check(viol_code == e_code, "R7 code", viol_code, e_code);
   endtask

   task automatic idle(input int n, input logic s);
      for (int i = 0; i < n; i++) drive(1, 1, s, 2'd0, 0);
   endtask

   task automatic expect_out(input string req, input logic p, input logic [3:0] f,
                             input logic [2:0] c);
      check(viol_pulse == p, req, viol_pulse, p);
      check(viol_flags == f, req, viol_flags, f);
      check(viol_code == c, req, viol_code, c);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'hC0FFEE));
      repeat (3) @(posedge clk);
      #1 expect_out("R9 reset", 0, 4'h0, 3'd0);
      @(negedge clk) rst_n = 1'b1;

      // R1: serial clock moves inside a write transfer
      drive(0, 1, 0, 2'd2, 0);
      drive(0, 0, 0, 2'd0, 0);
      drive(0, 0, 1, 2'd0, 0);
      expect_out("R1 frozen clock", 1, 4'b0001, 3'd1);
      drive(0, 0, 1, 2'd0, 0);
      drive(1, 1, 1, 2'd0, 0);
      idle(SRD + 1, 1);
      drive(1, 1, 0, 2'd0, 0);
      expect_out("R6 sticky", 0, 4'b0001, 3'd1);
      drive(1, 1, 0, 2'd0, 1);
      expect_out("R8 clear", 0, 4'h0, 3'd0);

      // R2: rise one cycle before the limit, then exactly on it
      drive(0, 1, 0, 2'd2, 0); drive(0, 0, 0, 2'd0, 0); drive(1, 1, 0, 2'd0, 0);
      idle(SRD - 2, 0);
      drive(1, 1, 1, 2'd0, 0);
      expect_out("R2 early rise", 1, 4'b0010, 3'd2);
      idle(2, 0);
      drive(1, 1, 0, 2'd0, 1);
      drive(0, 1, 0, 2'd3, 0); drive(0, 0, 0, 2'd0, 0); drive(1, 1, 0, 2'd0, 0);
      idle(SRD - 1, 0);
      drive(1, 1, 1, 2'd0, 0);
      expect_out("R2 rise at limit", 0, 4'h0, 3'd0);
      idle(1, 0);

      // R3: read transfer without column strobe
      drive(0, 1, 0, 2'd1, 0); drive(0, 1, 0, 2'd0, 0); drive(1, 1, 0, 2'd0, 0);
      expect_out("R3 no column", 1, 4'b0100, 3'd3);
      drive(1, 1, 1, 2'd0, 0);
      idle(RR + 1, 1);
      drive(1, 1, 0, 2'd0, 1);

      // R4: read after read, too soon then on the limit
      drive(0, 1, 0, 2'd1, 0); drive(0, 0, 0, 2'd0, 0); drive(1, 1, 0, 2'd0, 0);
      drive(1, 1, 1, 2'd0, 0);
      idle(RR - 2, 1);
      drive(0, 1, 1, 2'd1, 0);
      expect_out("R4 read too close", 1, 4'b1000, 3'd4);
      drive(0, 0, 1, 2'd0, 0); drive(1, 1, 1, 2'd0, 0);
      drive(1, 1, 0, 2'd0, 1);
      drive(1, 1, 1, 2'd0, 0);
      idle(RR - 1, 1);
      drive(0, 1, 1, 2'd1, 0);
      expect_out("R4 read at limit", 0, 4'h0, 3'd0);
      drive(0, 0, 1, 2'd0, 0); drive(1, 1, 1, 2'd0, 0);
      drive(1, 1, 1, 2'd0, 0);
      drive(0, 1, 1, 2'd1, 0);
      expect_out("R4 no serial rise", 1, 4'b1000, 3'd4);
      drive(0, 0, 1, 2'd0, 0); drive(1, 1, 1, 2'd0, 0);
      drive(1, 1, 1, 2'd0, 1);
      drive(0, 1, 1, 2'd2, 0); drive(0, 0, 1, 2'd0, 0); drive(1, 1, 1, 2'd0, 0);
      drive(1, 1, 1, 2'd0, 0);
      drive(0, 1, 1, 2'd1, 0);
      expect_out("R4 write cancels", 0, 4'h0, 3'd0);
      drive(0, 0, 1, 2'd0, 0); drive(1, 1, 1, 2'd0, 0);

      // R5: kind none cycle with clock toggles and no column strobe
      drive(0, 1, 1, 2'd0, 0); drive(0, 1, 0, 2'd0, 0); drive(0, 1, 1, 2'd0, 0);
      drive(1, 1, 1, 2'd0, 0);
      expect_out("R5 idle kind", 0, 4'h0, 3'd0);
      idle(SRD + RR, 1);
      drive(1, 1, 0, 2'd0, 0);

      // R7: two rules in one cycle, then a later lower code
      drive(0, 1, 0, 2'd2, 0); drive(0, 1, 0, 2'd0, 0); drive(1, 1, 1, 2'd0, 0);
      expect_out("R7 simultaneous", 1, 4'b0110, 3'd2);
      drive(0, 1, 1, 2'd2, 0); drive(0, 0, 1, 2'd0, 0); drive(0, 0, 0, 2'd0, 0);
      expect_out("R7 first kept", 1, 4'b0111, 3'd2);
      drive(1, 1, 0, 2'd0, 0);
      idle(SRD + 1, 0);

      // R8: violation in the clear cycle is kept
      drive(1, 1, 0, 2'd0, 1);
      drive(0, 1, 0, 2'd2, 0); drive(0, 0, 0, 2'd0, 0);
      drive(0, 0, 1, 2'd0, 1);
      expect_out("R8 hit with clear", 1, 4'b0001, 3'd1);
      drive(1, 1, 1, 2'd0, 0);
      drive(1, 1, 1, 2'd0, 1);
      expect_out("R8 clear again", 0, 4'h0, 3'd0);
      idle(SRD + RR, 1);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic r, c, s, cl;
         r  = (($urandom % 6) == 0) ? ~row : row;
         c  = (($urandom % 3) == 0) ? ~col : col;
         s  = (($urandom % 4) == 0) ? ~sc : sc;
         cl = (($urandom % 25) == 0);
         drive(r, c, s, 2'($urandom % 4), cl);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule